// File: doc/BRIEF.md
# Shared-Carry Select Adder

This block is a purely combinational binary adder of parameterised width. It takes two operands and a carry input and returns a sum word and a carry output. Unlike a classic carry select adder, it does not build two complete ripple adders. It forms the bitwise half-sum (XOR) and half-carry (AND) words once, and both carry candidates share them.

Two carry generators work side by side on those shared words. One assumes an incoming carry of 0 and the other assumes an incoming carry of 1. The real carry input then chooses between the two carry words. Because the carry is chosen before any sum bit exists, a single final XOR stage produces the result. The carry-0 word is always a bitwise subset of the carry-1 word, so the choice reduces to an OR with a gated term.

Several instances can be chained: one block's carry output drives the next block's carry input. This supports uniform or square-root segmented wide adders.

Top module: `shared_carry_select_adder`

## Requirements
- R1: With both operands zero and carry input 0, the sum and the carry output are all zero.
- R2: Half-sum bit i is opA[i] XOR opB[i] and half-carry bit i is opA[i] AND opB[i]; no bit position has both set.
- R3: The candidate carry word for an assumed carry of 1 has bit 0 equal to opA[0] OR opB[0], and the carry-0 candidate never has a 1 where the carry-1 candidate has a 0.
- R4: The selected carry word equals the carry-0 candidate when carryIn is 0 and the carry-1 candidate when carryIn is 1, so equal operands give results that differ by exactly one between the two carry inputs.
- R5: Sum bit 0 equals opA[0] XOR opB[0] XOR carryIn.
- R6: A carry that enters at bit 0 propagates through a full run of propagate bits: all-ones plus zero with carryIn 1 gives a zero sum and carry output 1, and 0xAAAA plus 0x5555 with carryIn 1 (width 16) does the same.
- R7: The carry output is bit WIDTH of opA + opB + carryIn; for example, 0x8000 + 0x8000 at width 16 gives sum 0 and carry output 1.
- R8: For every width, including 1 and 4, {carryOut, sumOut} equals opA + opB + carryIn over all input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| carryIn | input | 1 | Incoming carry |
| sumOut | output | WIDTH | Sum word |
| carryOut | output | 1 | Outgoing carry |

## Verification
The bench drives a carry in at bit 0 and propagates it across the full width. This exposes a selector that uses the wrong candidate, or a carry-1 generator whose bit 0 ignores the half-sum: either one would leave the upper sum bits unflipped and the carry output low. It also targets the most significant bit, because an off-by-one in the final sum stage or the carry output tap would lose the carry out of 0x8000 + 0x8000. The same operands are applied with both carry inputs to catch a selector stuck on one candidate. Width-1 and width-4 instances are checked exhaustively, to find a generate boundary that mishandles the lowest or highest bit.

// File: rtl/csa_pkg.sv
package csa_pkg;
  // Strobes from the carry-select control to the datapath.
  typedef struct packed {
    logic takeHigh;   // use the candidate built for an assumed carry of 1
    logic lsbFeed;    // carry that enters sum bit 0
  } selStrobeT;
endpackage

// File: rtl/csa_half_stage.sv
module csa_half_stage #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] halfSum,
  output logic [WIDTH-1:0] halfCarry
);
  assign halfSum   = opA ^ opB;
  assign halfCarry = opA & opB;
endmodule

// File: rtl/csa_carry_gen.sv
module csa_carry_gen #(
  parameter int WIDTH       = 16,
  parameter bit ASSUMED_CIN = 1'b0
) (
  input  logic [WIDTH-1:0] halfSum,
  input  logic [WIDTH-1:0] halfCarry,
  output logic [WIDTH-1:0] carryWord
);
  // With a fixed incoming carry, bit 0 folds into a constant choice.
  if (ASSUMED_CIN) begin : g_lsb_one
    assign carryWord[0] = halfCarry[0] | halfSum[0];
  end else begin : g_lsb_zero
    assign carryWord[0] = halfCarry[0];
  end

  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign carryWord[i] = halfCarry[i] | (halfSum[i] & carryWord[i-1]);
  end
endmodule

// File: rtl/csa_sel_ctrl.sv
module csa_sel_ctrl
  import csa_pkg::*;
(
  input  logic      carryIn,
  output selStrobeT strobes
);
  always_comb begin
    strobes.takeHigh = carryIn;
    strobes.lsbFeed  = carryIn;
  end
endmodule

// File: rtl/csa_datapath.sv
module csa_datapath
  import csa_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  selStrobeT        strobes,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int NUM_CAND = 2;

  logic [WIDTH-1:0] halfSum;
  logic [WIDTH-1:0] halfCarry;
  logic [WIDTH-1:0] carryCand [NUM_CAND];
  logic [WIDTH-1:0] pickedCarry;

  csa_half_stage #(.WIDTH(WIDTH)) u_half (
    .opA      (opA),
    .opB      (opB),
    .halfSum  (halfSum),
    .halfCarry(halfCarry)
  );

  for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
    csa_carry_gen #(.WIDTH(WIDTH), .ASSUMED_CIN(k == 1)) u_gen (
      .halfSum  (halfSum),
      .halfCarry(halfCarry),
      .carryWord(carryCand[k])
    );
  end

  // Carry-0 word is a bitwise subset of carry-1 word, so the choice is an OR.
  assign pickedCarry = carryCand[0] | ({WIDTH{strobes.takeHigh}} & carryCand[1]);

  assign sumOut[0] = halfSum[0] ^ strobes.lsbFeed;
  if (WIDTH > 1) begin : g_upper_sum
    assign sumOut[WIDTH-1:1] = halfSum[WIDTH-1:1] ^ pickedCarry[WIDTH-2:0];
  end
  assign carryOut = pickedCarry[WIDTH-1];

  always_comb begin
    a_r2_half_exclusive: assert ((halfSum & halfCarry) == '0)
      else $error("R2: half-sum and half-carry both set");
    a_r3_cand_order: assert ((carryCand[0] & ~carryCand[1]) == '0)
      else $error("R3: carry-0 candidate exceeds carry-1 candidate");
    a_r3_cand_lsb: assert (carryCand[1][0] == (opA[0] | opB[0]))
      else $error("R3: carry-1 candidate bit 0 wrong");
    a_r4_pick: assert (pickedCarry == (strobes.takeHigh ? carryCand[1] : carryCand[0]))
      else $error("R4: selected carry word does not match candidate");
  end
endmodule

// File: rtl/shared_carry_select_adder.sv
module shared_carry_select_adder
  import csa_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int RES_W = WIDTH + 1;

  selStrobeT strobes;

  csa_sel_ctrl u_ctrl (
    .carryIn(carryIn),
    .strobes(strobes)
  );

  csa_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );

  logic [RES_W-1:0] refTotal;
  assign refTotal = RES_W'(opA) + RES_W'(opB) + RES_W'(carryIn);

  always_comb begin
    a_r8_total: assert ({carryOut, sumOut} == refTotal)
      else $error("R8: result differs from plain addition");
    a_r5_lsb: assert (sumOut[0] == (opA[0] ^ opB[0] ^ carryIn))
      else $error("R5: sum bit 0 wrong");
  end
endmodule

// File: tb/shared_carry_select_adder_test.sv
`timescale 1ns/1ps
module shared_carry_select_adder_test;
  localparam int WIDE = 16;
  localparam int NARROW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [WIDE-1:0]   aW, bW, sW;
  logic              cW, coW;
  logic [NARROW-1:0] aN, bN, sN;
  logic              cN, coN;
  logic [0:0]        a1, b1, s1;
  logic              c1, co1;

  shared_carry_select_adder #(.WIDTH(WIDE)) uut (
    .opA(aW), .opB(bW), .carryIn(cW), .sumOut(sW), .carryOut(coW));
  shared_carry_select_adder #(.WIDTH(NARROW)) uutNarrow (
    .opA(aN), .opB(bN), .carryIn(cN), .sumOut(sN), .carryOut(coN));
  shared_carry_select_adder #(.WIDTH(1)) uutSingle (
    .opA(a1), .opB(b1), .carryIn(c1), .sumOut(s1), .carryOut(co1));

  function automatic logic [WIDE:0] refWide(logic [WIDE-1:0] a, logic [WIDE-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{WIDE{1'b0}}, c};
  endfunction

  function automatic logic [NARROW:0] refNarrow(logic [NARROW-1:0] a, logic [NARROW-1:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {{NARROW{1'b0}}, c};
  endfunction

  task automatic checkVal(string tag, logic [WIDE:0] got, logic [WIDE:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic applyWide(logic [WIDE-1:0] a, logic [WIDE-1:0] b, logic c);
    @(posedge clk); #1;
    aW = a; bW = b; cW = c;
    @(negedge clk);
  endtask

  task automatic runWide(string tag, logic [WIDE-1:0] a, logic [WIDE-1:0] b, logic c);
    applyWide(a, b, c);
    checkVal(tag, {coW, sW}, refWide(a, b, c));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDE:0] lo, hi;
    aW = '0; bW = '0; cW = 1'b0;
    aN = '0; bN = '0; cN = 1'b0;
    a1 = '0; b1 = '0; c1 = 1'b0;
    void'($urandom(32'd20240611));

    // R1: zero state
    applyWide('0, '0, 1'b0);
    checkVal("R1 zero", {coW, sW}, '0);

    // R6: full propagate runs
    applyWide(16'hFFFF, 16'h0000, 1'b1);
    checkVal("R6 ones+cin", {coW, sW}, 17'h10000);
    applyWide(16'hAAAA, 16'h5555, 1'b1);
    checkVal("R6 alternating+cin", {coW, sW}, 17'h10000);
    runWide("R6 alternating no cin", 16'hAAAA, 16'h5555, 1'b0);

    // R7: carry out from the top bit
    applyWide(16'h8000, 16'h8000, 1'b0);
    checkVal("R7 msb carry", {coW, sW}, 17'h10000);
    runWide("R7 max operands", 16'hFFFF, 16'hFFFF, 1'b1);

    // R4: same operands, both carry inputs differ by one
    applyWide(16'h1234, 16'h0FCB, 1'b0);
    lo = {coW, sW};
    applyWide(16'h1234, 16'h0FCB, 1'b1);
    hi = {coW, sW};
    checkVal("R4 cin step", hi, lo + 17'd1);
    checkVal("R4 cin0 value", lo, refWide(16'h1234, 16'h0FCB, 1'b0));

    // R5: sum bit 0 under all lsb combos
    for (int v = 0; v < 8; v++) begin
      applyWide({15'h0, v[0]}, {15'h0, v[1]}, v[2]);
      checkVal("R5 lsb", {16'h0, sW[0]}, {16'h0, v[0] ^ v[1] ^ v[2]});
    end

    // R2/R3: patterns that stress generate/propagate mixes
    runWide("R3 lsb generate", 16'h00FF, 16'h0001, 1'b0);
    runWide("R2 disjoint bits", 16'hF0F0, 16'h0F0F, 1'b0);

    // R8: random vectors at the default width
    for (int n = 0; n < 2000; n++) begin
      logic [WIDE-1:0] ra, rb;
      logic rc;
      ra = WIDE'($urandom);
      rb = WIDE'($urandom);
      rc = 1'($urandom);
      runWide("R8 random", ra, rb, rc);
    end

    // R8: exhaustive narrow width
    for (int v = 0; v < (1 << (2 * NARROW + 1)); v++) begin
      logic [NARROW:0] exp;
      @(posedge clk); #1;
      aN = v[NARROW-1:0];
      bN = v[2*NARROW-1:NARROW];
      cN = v[2*NARROW];
      @(negedge clk);
      exp = refNarrow(aN, bN, cN);
      checkVal("R8 narrow", {{(WIDE-NARROW){1'b0}}, coN, sN}, {{(WIDE-NARROW){1'b0}}, exp});
    end

    // R8: exhaustive single-bit width
    for (int v = 0; v < 8; v++) begin
      @(posedge clk); #1;
      a1 = v[0]; b1 = v[1]; c1 = v[2];
      @(negedge clk);
      checkVal("R8 single", {15'h0, co1, s1}, 17'(v[0] + v[1] + v[2]));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule